// File: doc/BRIEF.md
# MMU Fault Status Capture

This block keeps the two registers that describe the most recent failed address translation in a memory management unit: a status word and a fault address. Each cycle it looks at the result of the translation walker. When an attempt succeeds, both registers keep their values. When an attempt fails, the block records the access index, the fault code and the full virtual address. If an earlier fault was never read, the status first collapses to a single overflow marker, and the new fault is then merged into it.

The block also decides whether the processor is sent a trap. A one-cycle trap pulse, carrying the fault code, is raised only when traps are enabled and the no-fault control bit is clear. The registers are written in every case. Software reads either register through a small read port. A read of the status register with the read strobe high clears the register at the next clock edge. If a fault arrives in the same cycle as that read, the fault takes priority over the clear.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, the status register and the fault address register read as 0, and `trap_req` is low.
- R2: A fault taken while the status register is 0 leaves status = (access index << 5) | (fault code << 2) | 2. Bit 1 means the address is valid, bits 4:2 hold the code and bits 7:5 hold the access index, with the default 3-bit fields.
- R3: A fault taken while the status register is non-zero first replaces the status with 1, which is the overflow marker in bit 0. The new fault is then ORed in as in R2.
- R4: On every fault, the fault address register is loaded with the full faulting virtual address.
- R5: A cycle with no fault leaves the fault address register unchanged. This covers both a successful translation and an idle cycle. In such a cycle the status register is also unchanged unless it is read as in R6.
- R6: The read port returns the status register zero-extended when `rd_sel`=0, and the fault address when `rd_sel`=1. With `rd_en`=1 and `rd_sel`=0, the status value is returned in that cycle and the register is 0 after the next clock edge.
- R7: When a fault arrives in the same cycle as a clearing status read, the fault wins. The result is the pre-read status merged with the new fault as in R2 and R3.
- R8: A read of the fault address register (`rd_sel`=1) clears nothing.
- R9: A fault with `traps_en`=1 and `no_fault_mode`=0 raises `trap_req` for exactly the one cycle after the fault, with `trap_code` equal to the fault code.
- R10: When `no_fault_mode`=1 or `traps_en`=0, a fault raises no trap, but the status and address registers are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_valid | input | 1 | A translation result is presented this cycle |
| xl_fault | input | 1 | The presented translation failed |
| xl_acc | input | ACC_W | Access index of the attempt |
| xl_code | input | CODE_W | Fault code of the failed attempt |
| xl_vaddr | input | VA_W | Virtual address of the attempt |
| no_fault_mode | input | 1 | Control bit: record faults without trapping |
| traps_en | input | 1 | Processor trap enable |
| rd_en | input | 1 | Read strobe; clears status when `rd_sel`=0 |
| rd_sel | input | 1 | 0 selects status, 1 selects fault address |
| rd_data | output | VA_W | Selected register value (combinational) |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | CODE_W | Fault code belonging to the trap request |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume the inputs are held low during reset, so that the one-cycle look-back used for the trap check sees a quiet cycle. `xl_fault` only counts when `xl_valid` is high; the block gates it internally, so the assertions make no assumption about `xl_fault` alone. The bench changes all inputs on the falling edge and returns them to zero between scenarios. The read port is sampled with `rd_en` low whenever only an observation is wanted, so that observing never clears state.

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter int VA_W   = 32,
  parameter int ACC_W  = 3,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic              xl_fault,
  input  logic [ACC_W-1:0]  xl_acc,
  input  logic [CODE_W-1:0] xl_code,
  input  logic [VA_W-1:0]   xl_vaddr,
  input  logic              no_fault_mode,
  input  logic              traps_en,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [VA_W-1:0]   rd_data,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  localparam int ST_W = ACC_W + CODE_W + 2;

  logic [ST_W-1:0] stat;
  logic [VA_W-1:0] far;

  wire fault   = xl_valid & xl_fault;
  wire rd_clr  = rd_en & ~rd_sel;
  wire [ST_W-1:0] fresh = {xl_acc, xl_code, 2'b10};
  wire [ST_W-1:0] base  = (stat != '0) ? ST_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      far  <= '0;
    end else if (fault) begin
      stat <= base | fresh;
      far  <= xl_vaddr;
    end else if (rd_clr) begin
      stat <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_code <= '0;
    end else begin
      trap_req <= fault & traps_en & ~no_fault_mode;
      if (fault) trap_code <= xl_code;
    end
  end

  assign rd_data = rd_sel ? far : {{(VA_W-ST_W){1'b0}}, stat};

  AST_STATUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> stat[1]); // R2
  AST_OVERFLOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && stat != '0) |=> stat[0]); // R3
  AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> $stable(far)); // R5
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !fault) |=> stat == '0); // R6
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(fault)); // R9
  AST_TRAP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (no_fault_mode || !traps_en)) |=> !trap_req); // R10
endmodule

// File: tb/tb_mmu_fault_capture.sv
module tb_mmu_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xl_valid, xl_fault, no_fault_mode, traps_en, rd_en, rd_sel;
  logic [2:0]  xl_acc, xl_code;
  logic [31:0] xl_vaddr, rd_data;
  logic        trap_req;
  logic [2:0]  trap_code;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mmu_fault_capture dut (
    .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_fault(xl_fault),
    .xl_acc(xl_acc), .xl_code(xl_code), .xl_vaddr(xl_vaddr),
    .no_fault_mode(no_fault_mode), .traps_en(traps_en),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .trap_req(trap_req), .trap_code(trap_code));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    xl_valid = 0; xl_fault = 0; rd_en = 0; rd_sel = 0;
  endtask

  function automatic logic [31:0] peek(logic sel);
    return 32'(sel ? dut.rd_data : dut.rd_data);
  endfunction

  task automatic look(logic sel, output logic [31:0] v);
    rd_en = 0; rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic fault(logic [2:0] a, logic [2:0] c, logic [31:0] va);
    xl_valid = 1; xl_fault = 1; xl_acc = a; xl_code = c; xl_vaddr = va;
    step();
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    look(0, v); chk("R1 status", v, 0);
    look(1, v); chk("R1 address", v, 0);
    chk("R1 trap", trap_req, 0);
  endtask

  task automatic t_first_fault();
    logic [31:0] v;
    traps_en = 1; no_fault_mode = 0;
    fault(3'd3, 3'd5, 32'hDEAD_B000);
    chk("R9 trap pulse", trap_req, 1);
    chk("R9 trap code", trap_code, 5);
    look(0, v); chk("R2 status", v, 32'h76);
    look(1, v); chk("R4 address", v, 32'hDEAD_B000);
    step();
    chk("R9 pulse one cycle", trap_req, 0);
  endtask

  task automatic t_success();
    logic [31:0] v;
    xl_valid = 1; xl_fault = 0; xl_acc = 3'd7; xl_code = 3'd7; xl_vaddr = 32'h0BAD_0000;
    step(); idle();
    look(0, v); chk("R5 status kept", v, 32'h76);
    look(1, v); chk("R5 address kept", v, 32'hDEAD_B000);
    chk("R5 no trap", trap_req, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    fault(3'd1, 3'd2, 32'h0000_1234);
    look(0, v); chk("R3 overflow merge", v, 32'h2B);
    look(1, v); chk("R4 address", v, 32'h1234);
  endtask

  task automatic t_read_addr();
    logic [31:0] v;
    rd_en = 1; rd_sel = 1; #1;
    chk("R8 address read", rd_data, 32'h1234);
    step(); idle();
    look(0, v); chk("R8 status not cleared", v, 32'h2B);
    look(1, v); chk("R8 address kept", v, 32'h1234);
  endtask

  task automatic t_read_clear();
    logic [31:0] v;
    rd_en = 1; rd_sel = 0; #1;
    chk("R6 read value", rd_data, 32'h2B);
    step(); idle();
    look(0, v); chk("R6 cleared", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    fault(3'd2, 3'd1, 32'h0000_0044);
    look(0, v); chk("R2 status", v, 32'h46);
    rd_en = 1; rd_sel = 0;
    xl_valid = 1; xl_fault = 1; xl_acc = 3'd4; xl_code = 3'd3; xl_vaddr = 32'h55;
    #1; chk("R6 read value", rd_data, 32'h46);
    step(); idle();
    look(0, v); chk("R7 fault beats clear", v, 32'h8F);
    look(1, v); chk("R7 address", v, 32'h55);
    rd_en = 1; rd_sel = 0; step(); idle();
  endtask

  task automatic t_suppress();
    logic [31:0] v;
    no_fault_mode = 1; traps_en = 1;
    fault(3'd0, 3'd4, 32'h77);
    chk("R10 no-fault mode trap", trap_req, 0);
    look(0, v); chk("R10 status written", v, 32'h12);
    look(1, v); chk("R10 address written", v, 32'h77);
    no_fault_mode = 0; traps_en = 0;
    fault(3'd7, 3'd6, 32'h99);
    chk("R10 traps disabled", trap_req, 0);
    look(0, v); chk("R10 status written", v, 32'hFB);
    look(1, v); chk("R10 address written", v, 32'h99);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); xl_acc = 0; xl_code = 0; xl_vaddr = 0;
    no_fault_mode = 0; traps_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_first_fault();
    t_success();
    t_overflow();
    t_read_addr();
    t_read_clear();
    t_collide();
    t_suppress();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule